// File: doc/BRIEF.md
# Go-Back-N Sliding-Window Send Controller

This block is the sequence-control core for the sending side of a link that numbers frames with a 3-bit counter. It gives sequence numbers to an upstream frame source through a request/grant handshake. It keeps track of the window of frames that have been sent but not yet acknowledged. It takes decoded acknowledgements from the receive path, and it decides when the source must resend stored frames and when it must send new ones.

Acknowledgements are cumulative. Each one names the next frame the far end expects. There are three kinds. A ready acknowledgement frees frames and allows sending. A not-ready acknowledgement frees frames but pauses the sender. A reject rewinds the send pointer to the named frame, and every frame from that one onwards is sent again.

A timer watches the oldest outstanding frame. When it expires, the block asks for a poll frame and waits for the reply. The number carried by the reply sets the point where retransmission restarts. If too many polls go unanswered, the block raises a sticky link-reset request.

Top module: `gbn_tx_ctrl`

## Requirements
- R1: After reset the window is empty: `base_o` = 0, `out_cnt_o` = 0, and `poll_o`, `ack_err_o` and `link_reset_o` are all 0.
- R2: A grant with `gnt_retx_o` = 0 carries the next new sequence number. New numbers run 0,1,…,7 and then wrap to 0. Each new grant raises `out_cnt_o` by one.
- R3: At most 7 frames are outstanding. While `out_cnt_o` = 7, a request for a new frame is not granted.
- R4: An acknowledgement whose number n is in the window moves `base_o` to n. This frees every frame before n, and `out_cnt_o` becomes the distance from n to the next new number. In a cycle where `ack_valid_i` is high, no grant is given.
- R5: A not-ready acknowledgement (`ack_kind_i` = 01) frees frames in the same way as R4, but it blocks all grants. Only a later ready acknowledgement (`ack_kind_i` = 00) or a reject lets grants resume.
- R6: A reject (`ack_kind_i` = 10) numbered n causes the following grants to carry n, n+1, … up to the last frame already sent, each with `gnt_retx_o` = 1. New frames follow, with `gnt_retx_o` = 0.
- R7: The window is `base_o` to `base_o + out_cnt_o` (modulo 8). An acknowledgement number whose distance from `base_o` exceeds `out_cnt_o` is ignored: `base_o` and `out_cnt_o` do not change, and `ack_err_o` pulses for one cycle in the following cycle. Kind 11 is ignored completely and raises no error.
- R8: If frames are outstanding and `base_o` does not move for TMO_CYC cycles, `poll_o` pulses for one cycle. No grant is given until a reply arrives.
- R9: While a poll is pending, an in-window acknowledgement of kind ready or not-ready is taken as the reply. Sending restarts at its number, the reply restarts the timer, and the count of unanswered polls is cleared.
- R10: A poll that gets no reply is repeated on each later timeout, up to MAX_POLLS polls. On the next timeout after that, `link_reset_o` goes high and stays high, and all grants stop.
- R11: The timer restarts whenever `base_o` advances. It does not run while no frames are outstanding, so an idle link never polls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_req_i | input | 1 | Frame source is ready to send a frame |
| src_gnt_o | output | 1 | Grant: send the frame numbered `gnt_seq_o` this cycle |
| gnt_seq_o | output | SEQ_W | Sequence number of the granted frame |
| gnt_retx_o | output | 1 | Granted frame is a retransmission of a stored frame |
| ack_valid_i | input | 1 | Decoded acknowledgement present |
| ack_kind_i | input | 2 | 00 ready, 01 not-ready, 10 reject, 11 ignored |
| ack_num_i | input | SEQ_W | Next frame number the far end expects |
| poll_o | output | 1 | One-cycle request to send a poll frame |
| ack_err_o | output | 1 | One-cycle flag for an out-of-window acknowledgement |
| link_reset_o | output | 1 | Sticky request for a link reset |
| base_o | output | SEQ_W | Oldest unacknowledged sequence number |
| out_cnt_o | output | SEQ_W | Number of outstanding frames |

## Verification
The send path is tested with several patterns. A plain run of new frames that wraps past 7 checks numbering. A full window tests the cap of 7. A cumulative acknowledgement that skips frames shows that release is not frame-by-frame. A reject in the middle of the window shows whether the retransmitted frames and the new frames that follow them are ordered correctly. A not-ready/ready pair checks that grants are held and then released. The timing tests measure the exact cycle of each poll, which separates three cases: a timer that restarts on base advance, a timer that does not, and one that runs on an idle link. A chain of unanswered polls after a reply shows whether the poll count was cleared by that reply. Out-of-window and kind-11 acknowledgements are checked to leave the window untouched, with and without the error pulse.

// File: rtl/gbn_pkg.sv
package gbn_pkg;
    typedef enum logic [1:0] {
        ACK_READY  = 2'b00,
        ACK_HOLD   = 2'b01,
        ACK_REWIND = 2'b10,
        ACK_NONE   = 2'b11
    } ack_kind_e;
endpackage

// File: rtl/gbn_win_chk.sv
// Modular distance checks of an acknowledgement number against the window.
module gbn_win_chk #(
    parameter int SEQ_W = 3
) (
    input  logic [SEQ_W-1:0] base_i,
    input  logic [SEQ_W-1:0] next_i,
    input  logic [SEQ_W-1:0] send_i,
    input  logic [SEQ_W-1:0] num_i,
    output logic             in_win_o,
    output logic             advance_o,
    output logic             send_behind_o,
    output logic [SEQ_W-1:0] out_cnt_o
);
    logic [SEQ_W-1:0] d_num, d_next, d_send;

    always_comb begin
        d_num         = num_i - base_i;
        d_next        = next_i - base_i;
        d_send        = send_i - base_i;
        in_win_o      = (d_num <= d_next);
        advance_o     = (d_num != '0);
        send_behind_o = (d_send < d_num);
        out_cnt_o     = d_next;
    end
endmodule

// File: rtl/gbn_tmo_timer.sv
// Retransmission timer: expires after TMO_CYC running cycles.
module gbn_tmo_timer #(
    parameter int TMO_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic restart_i,
    output logic expire_o
);
    localparam int TW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

    logic [TW-1:0] tmr_d, tmr_q;

    always_comb begin
        expire_o = run_i && (tmr_q == LAST);
        if (!run_i || restart_i || expire_o) begin
            tmr_d = '0;
        end else begin
            tmr_d = tmr_q + TW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end
endmodule

// File: rtl/gbn_grant_arb.sv
// Decides whether the source request is granted this cycle.
module gbn_grant_arb #(
    parameter int SEQ_W = 3
) (
    input  logic             req_i,
    input  logic             ack_valid_i,
    input  logic             halt_i,
    input  logic             pwait_i,
    input  logic             lrst_i,
    input  logic [SEQ_W-1:0] send_i,
    input  logic [SEQ_W-1:0] next_i,
    input  logic [SEQ_W-1:0] out_cnt_i,
    output logic             gnt_o,
    output logic             retx_o
);
    localparam logic [SEQ_W-1:0] WIN = SEQ_W'((1 << SEQ_W) - 1);

    logic blocked, room;

    always_comb begin
        retx_o  = (send_i != next_i);
        room    = (out_cnt_i < WIN);
        blocked = ack_valid_i || halt_i || pwait_i || lrst_i;
        gnt_o   = req_i && !blocked && (retx_o || room);
    end
endmodule

// File: rtl/gbn_tx_ctrl.sv
module gbn_tx_ctrl
    import gbn_pkg::*;
#(
    parameter int SEQ_W     = 3,
    parameter int TMO_CYC   = 16,
    parameter int MAX_POLLS = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             src_req_i,
    output logic             src_gnt_o,
    output logic [SEQ_W-1:0] gnt_seq_o,
    output logic             gnt_retx_o,
    input  logic             ack_valid_i,
    input  logic [1:0]       ack_kind_i,
    input  logic [SEQ_W-1:0] ack_num_i,
    output logic             poll_o,
    output logic             ack_err_o,
    output logic             link_reset_o,
    output logic [SEQ_W-1:0] base_o,
    output logic [SEQ_W-1:0] out_cnt_o
);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] POLL_LIM = PW'(MAX_POLLS);

    typedef struct packed {
        logic [SEQ_W-1:0] base;
        logic [SEQ_W-1:0] next;
        logic [SEQ_W-1:0] send;
        logic             halt;
        logic             pwait;
        logic             lrst;
        logic             poll;
        logic             err;
        logic [PW-1:0]    polls;
    } st_t;

    st_t st_d, st_q;

    logic             in_win, advance, send_behind;
    logic [SEQ_W-1:0] out_cnt;
    logic             gnt, retx, expire, restart, run, ack_ok;
    ack_kind_e        kind;

    gbn_win_chk #(.SEQ_W(SEQ_W)) u_win (
        .base_i       (st_q.base),
        .next_i       (st_q.next),
        .send_i       (st_q.send),
        .num_i        (ack_num_i),
        .in_win_o     (in_win),
        .advance_o    (advance),
        .send_behind_o(send_behind),
        .out_cnt_o    (out_cnt)
    );

    gbn_grant_arb #(.SEQ_W(SEQ_W)) u_arb (
        .req_i      (src_req_i),
        .ack_valid_i(ack_valid_i),
        .halt_i     (st_q.halt),
        .pwait_i    (st_q.pwait),
        .lrst_i     (st_q.lrst),
        .send_i     (st_q.send),
        .next_i     (st_q.next),
        .out_cnt_i  (out_cnt),
        .gnt_o      (gnt),
        .retx_o     (retx)
    );

    assign run = ((st_q.base != st_q.next) || st_q.pwait) && !st_q.lrst;

    gbn_tmo_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run),
        .restart_i(restart),
        .expire_o (expire)
    );

    always_comb begin
        kind    = ack_kind_e'(ack_kind_i);
        ack_ok  = ack_valid_i && !st_q.lrst && (kind != ACK_NONE);
        st_d      = st_q;
        st_d.poll = 1'b0;
        st_d.err  = 1'b0;
        restart   = 1'b0;

        if (ack_ok) begin
            if (in_win) begin
                // cumulative release up to the named frame
                st_d.base = ack_num_i;
                if (advance) restart = 1'b1;
                if (st_q.pwait) begin
                    // reply to a poll: restart sending at its number
                    st_d.pwait = 1'b0;
                    st_d.polls = '0;
                    st_d.send  = ack_num_i;
                    restart    = 1'b1;
                end else if (kind == ACK_REWIND || send_behind) begin
                    st_d.send = ack_num_i;
                end
                st_d.halt = (kind == ACK_HOLD);
            end else begin
                st_d.err = 1'b1;
            end
        end else if (gnt) begin
            st_d.send = st_q.send + SEQ_W'(1);
            if (!retx) st_d.next = st_q.next + SEQ_W'(1);
        end

        if (expire && !restart && !st_q.lrst) begin
            if (st_q.polls == POLL_LIM) begin
                st_d.lrst = 1'b1;
            end else begin
                st_d.poll  = 1'b1;
                st_d.pwait = 1'b1;
                st_d.polls = st_q.polls + PW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign src_gnt_o    = gnt;
    assign gnt_seq_o    = st_q.send;
    assign gnt_retx_o   = retx;
    assign poll_o       = st_q.poll;
    assign ack_err_o    = st_q.err;
    assign link_reset_o = st_q.lrst;
    assign base_o       = st_q.base;
    assign out_cnt_o    = out_cnt;
endmodule

// File: rtl/gbn_tx_ctrl_chk.sv
module gbn_tx_ctrl_chk #(
    parameter int SEQ_W = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             src_gnt_o,
    input logic             gnt_retx_o,
    input logic             ack_valid_i,
    input logic             poll_o,
    input logic             ack_err_o,
    input logic             link_reset_o,
    input logic [SEQ_W-1:0] base_o,
    input logic [SEQ_W-1:0] out_cnt_o
);
    localparam logic [SEQ_W-1:0] WIN = SEQ_W'((1 << SEQ_W) - 1);

    a_r4_ack_blocks_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_valid_i |-> !src_gnt_o);

    a_r3_window_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_gnt_o && !gnt_retx_o) |-> (out_cnt_o < WIN));

    a_r2_new_grows_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_gnt_o && !gnt_retx_o) |=> (out_cnt_o == SEQ_W'($past(out_cnt_o) + 1)));

    a_r7_err_follows_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_err_o |-> $past(ack_valid_i));

    a_r7_err_keeps_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_err_o |-> $stable(base_o));

    a_r8_poll_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        poll_o |=> !poll_o);

    a_r10_reset_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_reset_o |=> link_reset_o);

    a_r10_no_grant_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_reset_o |-> !src_gnt_o);
endmodule

bind gbn_tx_ctrl gbn_tx_ctrl_chk #(.SEQ_W(SEQ_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_gnt_o   (src_gnt_o),
    .gnt_retx_o  (gnt_retx_o),
    .ack_valid_i (ack_valid_i),
    .poll_o      (poll_o),
    .ack_err_o   (ack_err_o),
    .link_reset_o(link_reset_o),
    .base_o      (base_o),
    .out_cnt_o   (out_cnt_o)
);

// File: tb/sim_gbn_tx_ctrl.sv
`timescale 1ns/1ps
module sim_gbn_tx_ctrl;
    localparam int SEQ_W = 3;
    localparam int TMO   = 16;
    localparam int MAXP  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_req = 1'b0;
    logic ack_valid = 1'b0;
    logic [1:0] ack_kind = 2'b00;
    logic [SEQ_W-1:0] ack_num = '0;
    logic src_gnt, gnt_retx, poll, ack_err, lreset;
    logic [SEQ_W-1:0] gnt_seq, base, out_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    seq;
        int    retx;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;

    gbn_tx_ctrl #(.SEQ_W(SEQ_W), .TMO_CYC(TMO), .MAX_POLLS(MAXP)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .src_req_i(src_req), .src_gnt_o(src_gnt),
        .gnt_seq_o(gnt_seq), .gnt_retx_o(gnt_retx),
        .ack_valid_i(ack_valid), .ack_kind_i(ack_kind), .ack_num_i(ack_num),
        .poll_o(poll), .ack_err_o(ack_err), .link_reset_o(lreset),
        .base_o(base), .out_cnt_o(out_cnt)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: every grant must match the head of the scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && src_gnt && !done) begin
            if (sbq.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL unexpected grant (R3/R4/R5/R8) actual=%0d expected=none", gnt_seq);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk({e.tag, " grant seq"}, int'(gnt_seq), e.seq);
                chk({e.tag, " grant retx"}, int'(gnt_retx), e.retx);
            end
        end
    end

    task automatic want(int seq, int retx, string tag);
        exp_t e;
        e.seq = seq; e.retx = retx; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic pulse_req(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); src_req = 1'b1;
        end
        @(negedge clk); src_req = 1'b0;
    endtask

    task automatic send_ack(int kind, int num, bit with_req);
        @(negedge clk);
        ack_valid = 1'b1; ack_kind = 2'(kind); ack_num = SEQ_W'(num);
        src_req = with_req;
        @(negedge clk);
        ack_valid = 1'b0; src_req = 1'b0;
        #1;
    endtask

    task automatic try_blocked(string tag);
        @(negedge clk); src_req = 1'b1;
        #1; chk(tag, int'(src_gnt), 0);
        @(negedge clk); src_req = 1'b0;
    endtask

    task automatic wait_sig(bit use_rst, output int k);
        k = 0;
        do begin
            @(negedge clk); #1; k++;
        end while (!(use_rst ? lreset : poll) && k < 200);
    endtask

    initial begin
        int k;
        int polls_seen;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 base", int'(base), 0);
        chk("R1 out_cnt", int'(out_cnt), 0);
        chk("R1 poll", int'(poll), 0);
        chk("R1 err", int'(ack_err), 0);
        chk("R1 lreset", int'(lreset), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: first new frames
        for (int s = 0; s < 3; s++) want(s, 0, "R2");
        pulse_req(3);
        #1; chk("R2 out_cnt", int'(out_cnt), 3);

        // R4: cumulative ready 2 with a request in the same cycle
        send_ack(0, 2, 1'b1);
        chk("R4 base", int'(base), 2);
        chk("R4 out_cnt", int'(out_cnt), 1);

        // R2 wrap and R3 full window
        for (int s = 3; s < 9; s++) want(s % 8, 0, "R2");
        pulse_req(6);
        #1; chk("R3 out_cnt full", int'(out_cnt), 7);
        try_blocked("R3 no grant at 7 outstanding");

        send_ack(0, 5, 1'b0);
        chk("R4 base skip", int'(base), 5);
        chk("R4 out_cnt skip", int'(out_cnt), 4);

        // R7: out-of-window and kind 11
        send_ack(0, 3, 1'b0);
        chk("R7 err pulse", int'(ack_err), 1);
        chk("R7 base kept", int'(base), 5);
        chk("R7 out kept", int'(out_cnt), 4);
        send_ack(3, 7, 1'b0);
        chk("R7 kind11 no err", int'(ack_err), 0);
        chk("R7 kind11 base kept", int'(base), 5);

        // R6: reject 7, resend 7 and 0, then new 1
        send_ack(2, 7, 1'b0);
        chk("R6 base", int'(base), 7);
        want(7, 1, "R6"); want(0, 1, "R6"); want(1, 0, "R6");
        pulse_req(3);
        #1; chk("R6 out_cnt", int'(out_cnt), 3);

        // R5: not-ready holds grants, ready releases them
        send_ack(1, 1, 1'b0);
        chk("R5 base", int'(base), 1);
        try_blocked("R5 held after not-ready");
        send_ack(0, 1, 1'b0);
        want(2, 0, "R5");
        pulse_req(1);
        send_ack(0, 3, 1'b0);
        chk("R4 empty window", int'(out_cnt), 0);

        // R11: idle link never polls
        polls_seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            if (poll) polls_seen++;
        end
        chk("R11 idle polls", polls_seen, 0);

        // R11 restart on base advance, R8 poll timing
        want(3, 0, "R2"); want(4, 0, "R2");
        pulse_req(2);
        repeat (10) @(negedge clk);
        send_ack(0, 4, 1'b0);
        wait_sig(1'b0, k);
        chk("R11 R8 cycles to poll after advance", k, TMO);
        try_blocked("R8 no grant while polling");

        // R9: reply restarts at its number
        send_ack(0, 4, 1'b0);
        chk("R9 base", int'(base), 4);
        want(4, 1, "R9");
        pulse_req(1);

        // R10: repeated polls then link reset (proves R9 cleared count)
        wait_sig(1'b0, k);
        chk("R9 poll after reply", int'(k <= TMO), 1);
        wait_sig(1'b0, k);
        chk("R10 second poll spacing", k, TMO);
        chk("R10 no reset yet", int'(lreset), 0);
        wait_sig(1'b1, k);
        chk("R10 reset after last poll", k, TMO);
        repeat (5) @(negedge clk);
        #1; chk("R10 reset held", int'(lreset), 1);
        try_blocked("R10 no grant in reset");

        chk("R2 scoreboard drained", sbq.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule